// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This unit holds the modem control register of a 16550-style serial port and builds its modem status register. Software writes the control register to drive two active-low handshake outputs (request-to-send and data-terminal-ready) and to select an internal loopback mode. Four active-low handshake inputs (clear-to-send, data-set-ready, ring indicate and carrier detect) are synchronized, turned into active-high levels and compared from cycle to cycle so that every change is latched in a sticky delta bit.

A read of the status register clears the delta bits, and the unit raises a modem interrupt request while any delta bit is set and the modem interrupt enable input is high. In loopback mode the control register bits stand in for the external inputs, so software can exercise the status path without a cable. The only signals the unit gives to the rest of the port are the interrupt request and the current clear-to-send level for flow control. Modem line state never touches the FIFOs.

Top module: `modem_ctl_stat`

## Requirements
- R1: Status bits 7..4 report carrier detect, ring indicate, data-set-ready and clear-to-send (bit 7 down to bit 4) as active-high levels, the inverse of the pins dcd_n, ri_n, dsr_n and cts_n. A pin change becomes visible on the third rising clock edge after it is applied, and not after the second.
- R2: Status bits 0, 1 and 3 are delta flags for clear-to-send, data-set-ready and carrier detect; each sets when its reported level changes in either direction, including a change caused by entering or leaving loopback. Bit 2 sets only when the reported ring level falls from 1 to 0.
- R3: Delta flags stay set until a clock edge at which msr_rd is high, which clears all four; a flag whose level changes at that same edge stays set.
- R4: irq is high exactly when mie is high and at least one delta flag is set.
- R5: A clock edge with mcr_wr high loads wdata[4:0] into the control register: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. With mcr_rd high, rdata shows the register with bits 7..5 as 0. The register resets to 0.
- R6: Outside loopback, dtr_n is the inverse of control bit 0 and rts_n the inverse of control bit 1; OUT1 and OUT2 change neither the pins nor the status bits.
- R7: In loopback, clear-to-send reports control bit 1, data-set-ready bit 0, ring indicate bit 2 (OUT1) and carrier detect bit 3 (OUT2); the external inputs are ignored and rts_n and dtr_n are held at 1.
- R8: The status register is read-only: an msr_wr strobe with any wdata changes neither register. With neither read strobe high, rdata is 0.
- R9: cts_ok equals the reported clear-to-send level, status bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mcr_wr | input | 1 | Control register write strobe |
| mcr_rd | input | 1 | Control register read strobe |
| msr_wr | input | 1 | Status register write strobe (no effect) |
| msr_rd | input | 1 | Status register read strobe; clears delta flags at the edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the strobed register, 0 when idle |
| mie | input | 1 | Modem interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicate pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| irq | output | 1 | Modem status interrupt request |
| cts_ok | output | 1 | Current clear-to-send level for flow control |

## Verification
The assertions assume that mcr_rd and msr_rd are never high together and that the strobes and pins are steady around the rising edge; the bench drives every input on the falling edge and never raises both read strobes at once. The delta checks also assume that a change of the reported level can only be seen one edge later in the status bits, which holds because pin changes pass through the synchronizer and loopback changes through the control register. Loopback is entered or left only while the pins are still, so each mode switch produces a single, predictable level change.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int MDM_LINES = 4;

  // bit positions of the handshake lines inside the level and delta nibbles
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef logic [MDM_LINES-1:0] mline_t;

  // control register, bit 0 at the bottom
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  localparam int MCTL_W = $bits(mctl_t);

  // only ring indicate reports its trailing edge alone
  localparam mline_t FALL_ONLY_MASK = mline_t'(1) << IDX_RI;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/modem_mctl.sv
module modem_mctl
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MCTL_W-1:0] wdata,
  output mctl_t             ctl,
  output logic              rts_n,
  output logic              dtr_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr) begin
      ctl <= mctl_t'(wdata);
    end
  end

  // loopback parks both outputs in their inactive state
  assign rts_n = ctl.loop | ~ctl.rts;
  assign dtr_n = ctl.loop | ~ctl.dtr;
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int               WIDTH     = 4,
  parameter logic [WIDTH-1:0] FALL_ONLY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] status_q,
  output logic [WIDTH-1:0] delta_q
);
  logic [WIDTH-1:0] chg;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
      if (FALL_ONLY[g]) begin : g_fall
        assign chg[g] = status_q[g] & ~lvl[g];
      end else begin : g_any
        assign chg[g] = status_q[g] ^ lvl[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      delta_q  <= '0;
    end else begin
      status_q <= lvl;
      // a new event at the read edge survives the clear
      delta_q  <= (delta_q & ~{WIDTH{rd_clr}}) | chg;
    end
  end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mcr_wr,
  input  logic              mcr_rd,
  input  logic              msr_wr,
  input  logic              msr_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              mie,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              irq,
  output logic              cts_ok
);
  localparam int MSR_W = 2 * MDM_LINES;

  mctl_t  ctl;
  mline_t ext_act;
  mline_t ext_sync;
  mline_t sel_lvl;
  mline_t stat_lvl;
  mline_t stat_delta;
  logic   unused_wr;

  // pins are active low; the status path works active high
  always_comb begin
    ext_act          = '0;
    ext_act[IDX_CTS] = ~cts_n;
    ext_act[IDX_DSR] = ~dsr_n;
    ext_act[IDX_RI]  = ~ri_n;
    ext_act[IDX_DCD] = ~dcd_n;
  end

  modem_sync #(
    .WIDTH  (MDM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_act),
    .q     (ext_sync)
  );

  modem_mctl u_mctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (mcr_wr),
    .wdata (wdata[MCTL_W-1:0]),
    .ctl   (ctl),
    .rts_n (rts_n),
    .dtr_n (dtr_n)
  );

  always_comb begin
    sel_lvl = ext_sync;
    if (ctl.loop) begin
      sel_lvl[IDX_CTS] = ctl.rts;
      sel_lvl[IDX_DSR] = ctl.dtr;
      sel_lvl[IDX_RI]  = ctl.out1;
      sel_lvl[IDX_DCD] = ctl.out2;
    end
  end

  modem_delta #(
    .WIDTH     (MDM_LINES),
    .FALL_ONLY (FALL_ONLY_MASK)
  ) u_delta (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (sel_lvl),
    .rd_clr   (msr_rd),
    .status_q (stat_lvl),
    .delta_q  (stat_delta)
  );

  always_comb begin
    rdata = '0;
    if (mcr_rd) begin
      rdata[MCTL_W-1:0] = ctl;
    end else if (msr_rd) begin
      rdata[MSR_W-1:0] = {stat_lvl, stat_delta};
    end
  end

  assign irq    = mie & (|stat_delta);
  assign cts_ok = stat_lvl[IDX_CTS];

  // the status register has no write path
  assign unused_wr = ^{msr_wr, wdata[DATA_W-1:MCTL_W]};
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mie,
  input logic       mcr_wr,
  input logic       mcr_rd,
  input logic       msr_rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       irq,
  input logic       cts_ok,
  input logic [3:0] status_q,
  input logic [3:0] delta_q
);
  assert_delta_cts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] != $past(status_q[0])) |-> delta_q[0]);
  assert_delta_dsr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] != $past(status_q[1])) |-> delta_q[1]);
  assert_delta_dcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[3] != $past(status_q[3])) |-> delta_q[3]);
  assert_ri_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q[2]) |-> delta_q[2]);
  assert_ri_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_q[2]) && !$past(delta_q[2])) |-> !delta_q[2]);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(msr_rd) |-> ((delta_q & $past(delta_q)) == $past(delta_q)));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msr_rd) && (status_q == $past(status_q))) |-> (delta_q == 4'b0000));
  assert_irq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |-> !irq);
  assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mie && (delta_q != 4'b0000)) |-> irq);
  assert_mcr_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_rd && !msr_rd) |-> (rdata[7:5] == 3'b000));
  assert_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mcr_wr) && !$past(wdata[4])) |->
      ((dtr_n == !$past(wdata[0])) && (rts_n == !$past(wdata[1]))));
  assert_loop_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mcr_wr) && $past(wdata[4])) |-> (rts_n && dtr_n));
  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcr_rd && !msr_rd) |-> (rdata == 8'h00));
  assert_cts_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !mcr_rd) |-> (rdata[4] == cts_ok));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mie      (mie),
  .mcr_wr   (mcr_wr),
  .mcr_rd   (mcr_rd),
  .msr_rd   (msr_rd),
  .wdata    (wdata),
  .rdata    (rdata),
  .rts_n    (rts_n),
  .dtr_n    (dtr_n),
  .irq      (irq),
  .cts_ok   (cts_ok),
  .status_q (stat_lvl),
  .delta_q  (stat_delta)
);

// File: tb/modem_ctl_stat_tb.sv
module modem_ctl_stat_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // pins_n order {dcd_n, ri_n, dsr_n, cts_n}; msr is the expected status byte
  typedef struct packed {
    logic [3:0] pins_n;
    logic [7:0] mcr;
    logic [7:0] msr;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'b1110, 8'h00, 8'h11},  // R1 R2 cts asserts
    '{4'b1100, 8'hE3, 8'h32},  // R2 dsr asserts, R5 upper bits dropped
    '{4'b1000, 8'h03, 8'h70},  // R2 ring rise sets nothing
    '{4'b1100, 8'h03, 8'h34},  // R2 ring trailing edge
    '{4'b0100, 8'h03, 8'hB8},  // R2 carrier asserts
    '{4'b1111, 8'h00, 8'h0B},  // R2 three lines drop together
    '{4'b1111, 8'h13, 8'h33},  // R7 enter loopback
    '{4'b0000, 8'h1C, 8'hCB},  // R7 pins ignored, OUT1/OUT2 feed ri/dcd
    '{4'b0000, 8'h18, 8'h84},  // R7 OUT1 off gives ring trailing edge
    '{4'b0000, 8'h00, 8'hF3},  // R2 leave loopback
    '{4'b0000, 8'h0C, 8'hF0}   // R6 OUT1/OUT2 inert outside loopback
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcr_wr = 1'b0, mcr_rd = 1'b0, msr_wr = 1'b0, msr_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       mie = 1'b1;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       rts_n, dtr_n, irq, cts_ok;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl_stat u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .mcr_wr (mcr_wr),
    .mcr_rd (mcr_rd),
    .msr_wr (msr_wr),
    .msr_rd (msr_rd),
    .wdata  (wdata),
    .rdata  (rdata),
    .mie    (mie),
    .cts_n  (cts_n),
    .dsr_n  (dsr_n),
    .ri_n   (ri_n),
    .dcd_n  (dcd_n),
    .rts_n  (rts_n),
    .dtr_n  (dtr_n),
    .irq    (irq),
    .cts_ok (cts_ok)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_pins(input logic [3:0] p);
    cts_n = p[0];
    dsr_n = p[1];
    ri_n  = p[2];
    dcd_n = p[3];
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // reset state
    check("R5 reset pins", {6'b0, rts_n, dtr_n}, 8'h03);
    check("R4 reset irq", {7'b0, irq}, 8'h00);
    check("R9 reset cts_ok", {7'b0, cts_ok}, 8'h00);
    check("R8 idle rdata", rdata, 8'h00);
    mcr_rd = 1'b1; #1;
    check("R5 reset mcr", rdata, 8'h00);
    mcr_rd = 1'b0; msr_rd = 1'b1; #1;
    check("R1 reset msr", rdata, 8'h00);
    @(negedge clk);
    msr_rd = 1'b0;

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      set_pins(VECS[v].pins_n);
      mcr_wr = 1'b1;
      wdata  = VECS[v].mcr;
      @(negedge clk);
      mcr_wr = 1'b0;
      wdata  = 8'h00;
      @(negedge clk);
      @(negedge clk);
      mcr_rd = 1'b1; #1;
      check("R5 mcr readback", rdata, VECS[v].mcr & 8'h1F);
      if (VECS[v].mcr[4])
        check("R7 loop pins", {6'b0, rts_n, dtr_n}, 8'h03);
      else
        check("R6 pins", {6'b0, rts_n, dtr_n}, {6'b0, ~VECS[v].mcr[1], ~VECS[v].mcr[0]});
      check("R9 cts_ok", {7'b0, cts_ok}, {7'b0, VECS[v].msr[4]});
      check("R4 irq", {7'b0, irq}, {7'b0, |VECS[v].msr[3:0]});
      mcr_rd = 1'b0; msr_rd = 1'b1; #1;
      check("R2 msr", rdata, VECS[v].msr);
      @(negedge clk);
      #1;
      check("R3 msr after read", rdata, VECS[v].msr & 8'hF0);
      msr_rd = 1'b0;
    end

    // R1 latency and R3 change at the read edge; status now 0xF0
    @(negedge clk);
    set_pins(4'b0001);
    @(negedge clk);
    @(negedge clk);
    msr_rd = 1'b1; #1;
    check("R1 not visible after two edges", rdata, 8'hF0);
    @(negedge clk);
    msr_rd = 1'b0;
    mie = 1'b0;
    #1;
    check("R4 irq masked", {7'b0, irq}, 8'h00);
    msr_rd = 1'b1; #1;
    check("R3 change at read edge kept", rdata, 8'hE1);
    msr_rd = 1'b0;
    mie = 1'b1; #1;
    check("R4 irq enabled", {7'b0, irq}, 8'h01);

    // R8 writes to the status register are ignored
    msr_wr = 1'b1;
    wdata  = 8'hFF;
    @(negedge clk);
    msr_wr = 1'b0;
    wdata  = 8'h00;
    msr_rd = 1'b1; #1;
    check("R8 msr after write", rdata, 8'hE1);
    msr_rd = 1'b0; mcr_rd = 1'b1; #1;
    check("R8 mcr after msr write", rdata, 8'h0C);
    mcr_rd = 1'b0; #1;
    check("R8 idle rdata", rdata, 8'h00);

    // R1 assertion visible on third edge, R9 follows
    msr_rd = 1'b1;
    @(negedge clk);
    msr_rd = 1'b0;
    set_pins(4'b0000);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R9 cts_ok after assert", {7'b0, cts_ok}, 8'h01);
    msr_rd = 1'b1; #1;
    check("R1 visible after three edges", rdata, 8'hF1);
    @(negedge clk);
    msr_rd = 1'b0; #1;
    check("R3 irq after clear", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule